// File: doc/BRIEF.md
# Secure Watchdog Countdown Timer

This block counts down a programmed interval and, when the interval runs out, asks the mode controller to enter the protected execution mode. A 16-bit prescaler divides the system clock. Each time the prescaler completes a period, a 16-bit down-counter steps down by one. The down-counter is loaded with a start value through its own strobe. When the counter steps from 1 to 0, the block raises a trap request for exactly one cycle.

Software reaches the block through one 32-bit register view. A write sets the prescaler from the low half of the data word. A read returns the live count in the upper half and the prescaler in the lower half. A secure-mode qualifier guards every access: outside secure mode, reads return zero and writes and loads have no effect. Writing a prescaler of zero freezes the countdown where it stands.

Top module: `sec_wdog_timer`

## Requirements
- R1: After a synchronous reset, the count and the prescaler are 0, `trap_o` is low, and a secure read returns 0x00000000.
- R2: A secure read returns the live count in bits 31:16 and the prescaler in bits 15:0 of `rd_data_o`.
- R3: A secure `reg_we_i` pulse copies `wr_data_i[15:0]` into the prescaler. `wr_data_i[31:16]` has no effect on any state.
- R4: A secure `start_we_i` pulse loads `wr_data_i[15:0]` into the count and restarts the prescaler phase at zero.
- R5: With a prescaler value P other than 0, the count drops by one every P+1 clock cycles, with the first drop P+1 edges after the load edge.
- R6: When the count steps from 1 to 0, `trap_o` is high for exactly the one cycle after that edge. After that, the count stays at 0 and no further trap occurs until the next load.
- R7: While the prescaler is 0, the count holds its value and no trap is raised. Writing a nonzero prescaler again resumes the countdown.
- R8: Loading a start value of 0 never produces a trap. The count stays 0.
- R9: While `secure_i` is low, `rd_data_o` reads 0 and `reg_we_i` and `start_we_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| secure_i | input | 1 | High while the access comes from secure mode |
| reg_we_i | input | 1 | Write strobe for the prescaler field |
| start_we_i | input | 1 | Strobe that loads the start value into the count |
| wr_data_i | input | 32 | Write data; only bits 15:0 are used |
| rd_data_o | output | 32 | Register view: count in 31:16, prescaler in 15:0 |
| trap_o | output | 1 | One-cycle request to enter secure mode |

## Verification
Several properties are checked on every cycle:
- A trap only coincides with a zero count and never lasts two cycles.
- The count never moves by more than one step without a load.
- A zero prescaler or an exhausted count keeps the count still.
- Non-secure writes leave the prescaler untouched.

The exact trap latency of S*(P+1) cycles and the intermediate count values can only be shown by the bench's timed scenarios, which walk a table of prescaler and start-value pairs. The same applies to resuming after a freeze and to the readback of masked and non-secure accesses.

// File: rtl/sec_wdog_pkg.sv
package sec_wdog_pkg;

    localparam int CNT_W = 16;
    localparam int PSC_W = 16;
    localparam int REG_W = 32;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [PSC_W-1:0] psc;
    } wdog_view_t;

    function automatic logic [REG_W-1:0] pack_view(input logic [CNT_W-1:0] cnt,
                                                   input logic [PSC_W-1:0] psc);
        wdog_view_t v;
        v.count = cnt;
        v.psc   = psc;
        return v;
    endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] limit,
    input  logic         restart,
    output logic         tick
);
    logic [W-1:0] phase;
    logic         running;

    assign running = (limit != '0);
    assign tick    = running && (phase >= limit);

    always_ff @(posedge clk) begin
        if (rst)            phase <= '0;
        else if (restart)   phase <= '0;
        else if (!running)  phase <= phase;
        else if (tick)      phase <= '0;
        else                phase <= phase + 1'b1;
    end

    // R5: a tick always restarts the phase at the next edge
    assert_tick_restart_R5: assert property (@(posedge clk) disable iff (rst)
        tick |=> (phase == '0));

endmodule

// File: rtl/wdog_downcount.sv
module wdog_downcount #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] count,
    output logic         trap
);
    localparam logic [W-1:0] ONE = W'(1);

    logic expire;
    assign expire = step && !load && (count == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            trap  <= 1'b0;
        end else begin
            trap <= expire;
            if (load)                       count <= load_val;
            else if (step && count != '0)   count <= count - 1'b1;
        end
    end

    assert_trap_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
        trap |-> (count == '0));

    assert_trap_single_R6: assert property (@(posedge clk) disable iff (rst)
        trap |=> !trap);

    assert_one_step_R5: assert property (@(posedge clk) disable iff (rst)
        !load |=> (count == $past(count)) || (count == $past(count) - 1'b1));

endmodule

// File: rtl/sec_wdog_timer.sv
module sec_wdog_timer
    import sec_wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        secure_i,
    input  logic        reg_we_i,
    input  logic        start_we_i,
    input  logic [31:0] wr_data_i,
    output logic [31:0] rd_data_o,
    output logic        trap_o
);
    logic [PSC_W-1:0] psc_q;
    logic [CNT_W-1:0] count;
    logic             psc_wr;
    logic             ld;
    logic             tick;

    assign psc_wr = secure_i && reg_we_i;
    assign ld     = secure_i && start_we_i;

    always_ff @(posedge clk) begin
        if (rst)         psc_q <= '0;
        else if (psc_wr) psc_q <= wr_data_i[PSC_W-1:0];
    end

    wdog_prescaler #(.W(PSC_W)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .limit   (psc_q),
        .restart (ld),
        .tick    (tick)
    );

    wdog_downcount #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (wr_data_i[CNT_W-1:0]),
        .step     (tick),
        .count    (count),
        .trap     (trap_o)
    );

    assign rd_data_o = secure_i ? pack_view(count, psc_q) : '0;

    assert_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        (psc_q == '0 && !ld) |=> $stable(count) && !trap_o);

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !ld) |=> (count == '0) && !trap_o);

    assert_nonsecure_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (!secure_i) |=> $stable(psc_q));

endmodule

// File: tb/sec_wdog_timer_tb.sv
module sec_wdog_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        secure_i = 1'b1;
    logic        reg_we_i = 1'b0;
    logic        start_we_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] rd_data_o;
    logic        trap_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sec_wdog_timer u_dut (
        .clk(clk), .rst(rst), .secure_i(secure_i), .reg_we_i(reg_we_i),
        .start_we_i(start_we_i), .wr_data_i(wr_data_i),
        .rd_data_o(rd_data_o), .trap_o(trap_o)
    );

    // {prescaler, start value}; expected trap latency S*(P+1)
    localparam int NV = 8;
    localparam logic [31:0] VEC [NV] = '{
        {16'd1,  16'd4},  {16'd2,  16'd3},  {16'd4,  16'd1},  {16'd7, 16'd5},
        {16'd15, 16'd2},  {16'd1,  16'd1},  {16'd3,  16'd10}, {16'd5, 16'd6}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic write_psc(input logic [31:0] d);
        reg_we_i = 1'b1; wr_data_i = d;
        @(posedge clk); @(negedge clk);
        reg_we_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic load_start(input logic [31:0] d);
        start_we_i = 1'b1; wr_data_i = d;
        @(posedge clk); @(negedge clk);
        start_we_i = 1'b0; wr_data_i = '0;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        check(rd_data_o == 32'h0, "R1 reset readback", rd_data_o, 0);
        check(trap_o == 1'b0, "R1 reset trap", trap_o, 0);

        // R3: upper write bits ignored; R2 readback layout
        write_psc(32'hFFFF_0003);
        check(rd_data_o == 32'h0000_0003, "R3 upper bits ignored / R2 layout", rd_data_o, 32'h3);

        // Table walk: R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            int p, s, n, lim;
            bit seen;
            p = int'(VEC[i][31:16]);
            s = int'(VEC[i][15:0]);
            write_psc({16'h0, VEC[i][31:16]});
            load_start({16'h0, VEC[i][15:0]});
            check(rd_data_o == {VEC[i][15:0], VEC[i][31:16]}, "R4 load readback",
                  rd_data_o, {VEC[i][15:0], VEC[i][31:16]});
            n = 0; seen = 0; lim = s * (p + 1) + 20;
            while (!seen && n < lim) begin
                @(posedge clk); n++; @(negedge clk);
                if (n == p + 1 && s > 1)
                    check(rd_data_o[31:16] == 16'(s - 1), "R5 first decrement",
                          rd_data_o[31:16], s - 1);
                if (trap_o) seen = 1;
            end
            check(seen && n == s * (p + 1), "R5 trap latency", n, s * (p + 1));
            check(rd_data_o[31:16] == 16'h0, "R6 count zero at trap", rd_data_o[31:16], 0);
            @(negedge clk);
            check(trap_o == 1'b0, "R6 single-cycle trap", trap_o, 0);
            repeat (3 * (p + 1)) @(negedge clk);
            check(trap_o == 1'b0 && rd_data_o[31:16] == 16'h0, "R6 stays at zero",
                  rd_data_o[31:16], 0);
        end

        // R7: freeze and resume
        write_psc(32'd3);
        load_start(32'd10);
        repeat (8) @(negedge clk);             // edges 4 and 8 decrement
        check(rd_data_o[31:16] == 16'd8, "R5 live count", rd_data_o[31:16], 8);
        write_psc(32'd0);
        begin
            logic [15:0] held;
            bit tr;
            held = rd_data_o[31:16];
            tr = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (trap_o) tr = 1;
            end
            check(rd_data_o[31:16] == held && !tr, "R7 frozen", rd_data_o[31:16], held);
            write_psc(32'd1);
            repeat (6) @(negedge clk);
            check(rd_data_o[31:16] < held, "R7 resumed", rd_data_o[31:16], held - 1);
        end

        // R8: start of zero never traps
        write_psc(32'd1);
        load_start(32'd0);
        begin
            bit tr;
            tr = 0;
            for (int k = 0; k < 50; k++) begin
                @(negedge clk);
                if (trap_o) tr = 1;
            end
            check(!tr && rd_data_o[31:16] == 16'h0, "R8 zero start no trap", tr, 0);
        end

        // R9: non-secure accesses
        write_psc(32'd0);
        load_start(32'd9);
        check(rd_data_o == 32'h0009_0000, "R9 setup", rd_data_o, 32'h0009_0000);
        secure_i = 1'b0;
        #1;
        check(rd_data_o == 32'h0, "R9 nonsecure read zero", rd_data_o, 0);
        write_psc(32'd5);
        load_start(32'd2);
        secure_i = 1'b1;
        #1;
        check(rd_data_o == 32'h0009_0000, "R9 nonsecure writes ignored",
              rd_data_o, 32'h0009_0000);

        // R1: reset clears state mid-count
        write_psc(32'd2);
        load_start(32'd7);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        check(rd_data_o == 32'h0 && !trap_o, "R1 reset mid-count", rd_data_o, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule